// File: doc/BRIEF.md
# Single-Precision Floating-Point Adder

This block adds or subtracts two 32-bit binary floating-point operands and returns the sum rounded to nearest, with ties going to the even value. It is a two-stage pipeline. The first stage orders the operands by magnitude. It then shifts the smaller significand right to the larger exponent and keeps three extra low bits for rounding. Last, it adds or subtracts the two significands according to their effective signs. The second stage renormalises the result: one place right when the significand overflows, or left by the leading-zero count when terms cancel. The left shift is limited so that tiny results become denormals. The second stage then rounds, renormalises again if rounding carried, and packs the word.

A caller presents both operands together with `valid_i` and chooses subtraction with `sub_i`. Subtraction inverts the sign of the second operand at the input. Zero, denormal, infinite and NaN encodings are all accepted. The block accepts one operation per cycle and produces one result per cycle. Two flags come with each result: one for overflow to infinity and one for invalid operations.

Top module: `sp_fadd`

## Requirements
- R1: A result appears on `sum_o` with `valid_o` high exactly two clock cycles after `valid_i` is sampled high. A new operation may start every cycle, and `valid_o` is low in every cycle that has no operation two cycles earlier.
- R2: For finite operands whose rounded sum is finite, `sum_o` is the exact sum rounded to the nearest representable value. On an exact tie, the result is the one whose fraction LSB (bit 0) is 0.
- R3: With `sub_i` = 1 the block returns a - b, computed as a + b with bit 31 of b inverted.
- R4: When the exact sum is zero, the result is +0 (0x00000000). The only exception is when both effective operands are negative zero, which gives 0x80000000.
- R5: When the rounded magnitude reaches 2^128 or more, the result is infinity with the sign of the exact sum (exponent field 0xFF, fraction 0), and `ovf_o` is 1. Otherwise `ovf_o` is 0.
- R6: An operand with exponent 0xFF and a nonzero fraction is a NaN, and it gives the quiet NaN 0x7FC00000. `inv_o` is 1 when some NaN operand has fraction bit 22 equal to 0 (a signalling NaN).
- R7: Infinities of opposite effective sign give 0x7FC00000 with `inv_o` = 1.
- R8: Infinity combined with a finite operand, or with an infinity of the same sign, returns that infinity with both flags 0.
- R9: When the exponent gap exceeds 26, the smaller operand affects the result only through its sticky contribution to rounding.
- R10: When rounding carries the significand up to 2.0, the exponent increases by one and the fraction becomes 0. This includes a carry out of the largest denormal into the smallest normal.
- R11: While `rst_ni` is low, `valid_o`, `ovf_o` and `inv_o` are 0.
- R12: `ovf_o` and `inv_o` are 0 in every cycle in which `valid_o` is 0.
- R13: Denormal operands (exponent field 0) have value fraction x 2^-149, and sums below 2^-126 are returned as denormals without loss.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operands present this cycle |
| sub_i | input | 1 | 1: compute a - b; 0: a + b |
| a_i | input | 32 | First operand, sign/exponent/fraction |
| b_i | input | 32 | Second operand |
| valid_o | output | 1 | Result present this cycle |
| sum_o | output | 32 | Rounded result |
| ovf_o | output | 1 | Result overflowed to infinity |
| inv_o | output | 1 | Invalid operation (inf - inf or signalling NaN) |

## Verification
The operand pairs are chosen to reach different paths through the datapath. Fully random words exercise every encoding class and large exponent gaps. Pairs with nearby exponents and mixed signs drive the one-place right shift on significand overflow. Near-negatives of the first operand cause deep cancellation, which stresses the leading-zero left shift and the clamp that produces denormals. Hand-picked words isolate the remaining cases: exact ties that must go to even, the half-ulp boundary at the top of the range that separates overflow from no overflow, rounding carries into a new binade, signed-zero results, and each NaN and infinity combination.

// File: rtl/fpa_pkg.sv
package fpa_pkg;
  localparam int EXP_W  = 8;
  localparam int FRAC_W = 23;
  localparam int WORD_W = 1 + EXP_W + FRAC_W;
  localparam int SIG_W  = FRAC_W + 1;
  localparam int GRS_W  = 3;
  localparam int EXT_W  = SIG_W + GRS_W;
  localparam int SUM_W  = EXT_W + 1;
  localparam int SH_W   = $clog2(EXT_W + 1);
  localparam logic [EXP_W-1:0]  EXP_ONES = '1;
  localparam logic [WORD_W-1:0] QNAN =
    {1'b0, EXP_ONES, 1'b1, {(FRAC_W-1){1'b0}}};

  typedef struct packed {
    logic              special;
    logic [WORD_W-1:0] sp_word;
    logic              sp_inv;
    logic              sign;
    logic [EXP_W:0]    exp;
    logic [SUM_W-1:0]  mag;
  } fpa_mid_t;
endpackage

// File: rtl/fpa_lzc.sv
module fpa_lzc #(
  parameter  int W  = 27,
  localparam int CW = $clog2(W + 1)
) (
  input  logic [W-1:0]  d_i,
  output logic [CW-1:0] cnt_o
);
  always_comb begin
    cnt_o = CW'(W);
    for (int i = 0; i < W; i++)
      if (d_i[i]) cnt_o = CW'(W - 1 - i);
  end
endmodule

// File: rtl/fpa_align.sv
module fpa_align
  import fpa_pkg::*;
(
  input  logic [WORD_W-1:0] a_i,
  input  logic [WORD_W-1:0] b_i,
  input  logic              sub_i,
  output fpa_mid_t          mid_o
);
  logic sa, sb, a_nan, b_nan, a_inf, b_inf, a_snan, b_snan, clash, swap;
  logic [EXP_W-1:0]  ea, eb, e_big, e_sml, x_big, x_sml, diff;
  logic [FRAC_W-1:0] fa, fb, f_big, f_sml;
  logic              s_big, s_sml, sticky;
  logic [SH_W-1:0]   shamt;
  logic [EXT_W-1:0]  ext_big, ext_sml, sml_sh, lost_mask;
  logic [SUM_W-1:0]  mag;

  always_comb begin
    sa = a_i[WORD_W-1];
    sb = b_i[WORD_W-1] ^ sub_i;
    ea = a_i[WORD_W-2:FRAC_W];
    eb = b_i[WORD_W-2:FRAC_W];
    fa = a_i[FRAC_W-1:0];
    fb = b_i[FRAC_W-1:0];
    a_nan  = (ea == EXP_ONES) && (fa != '0);
    b_nan  = (eb == EXP_ONES) && (fb != '0);
    a_inf  = (ea == EXP_ONES) && (fa == '0);
    b_inf  = (eb == EXP_ONES) && (fb == '0);
    a_snan = a_nan && !fa[FRAC_W-1];
    b_snan = b_nan && !fb[FRAC_W-1];
    clash  = a_inf && b_inf && (sa != sb);

    // order by magnitude so the subtraction below never goes negative
    swap = b_i[WORD_W-2:0] > a_i[WORD_W-2:0];
    {s_big, e_big, f_big} = swap ? {sb, eb, fb} : {sa, ea, fa};
    {s_sml, e_sml, f_sml} = swap ? {sa, ea, fa} : {sb, eb, fb};
    x_big = (e_big == '0) ? EXP_W'(1) : e_big;
    x_sml = (e_sml == '0) ? EXP_W'(1) : e_sml;
    diff  = x_big - x_sml;
    shamt = (diff > EXP_W'(EXT_W - 1)) ? SH_W'(EXT_W) : diff[SH_W-1:0];

    ext_big   = {(e_big != '0), f_big, {GRS_W{1'b0}}};
    ext_sml   = {(e_sml != '0), f_sml, {GRS_W{1'b0}}};
    sml_sh    = ext_sml >> shamt;
    lost_mask = ~({EXT_W{1'b1}} << shamt);
    sticky    = |(ext_sml & lost_mask);
    sml_sh[0] = sml_sh[0] | sticky;

    mag = (s_big ^ s_sml) ? ({1'b0, ext_big} - {1'b0, sml_sh})
                          : ({1'b0, ext_big} + {1'b0, sml_sh});

    mid_o.mag     = mag;
    mid_o.exp     = {1'b0, x_big};
    mid_o.sign    = (mag == '0) ? (sa & sb) : s_big;
    mid_o.special = 1'b0;
    mid_o.sp_word = '0;
    mid_o.sp_inv  = 1'b0;
    if (a_nan || b_nan || clash) begin
      mid_o.special = 1'b1;
      mid_o.sp_word = QNAN;
      mid_o.sp_inv  = a_snan | b_snan | clash;
    end else if (a_inf) begin
      mid_o.special = 1'b1;
      mid_o.sp_word = {sa, EXP_ONES, {FRAC_W{1'b0}}};
    end else if (b_inf) begin
      mid_o.special = 1'b1;
      mid_o.sp_word = {sb, EXP_ONES, {FRAC_W{1'b0}}};
    end
  end
endmodule

// File: rtl/fpa_normrnd.sv
module fpa_normrnd
  import fpa_pkg::*;
(
  input  fpa_mid_t          mid_i,
  output logic [WORD_W-1:0] word_o,
  output logic              ovf_o,
  output logic              inv_o
);
  localparam int EW = EXP_W + 2;
  localparam int RW = SIG_W + 1;

  logic [SH_W-1:0]   lz;
  logic [EW-1:0]     room, k, e_n, e_r;
  logic [EXT_W-1:0]  nrm;
  logic [SIG_W-1:0]  keep;
  logic              inc;
  logic [RW-1:0]     rnd;
  logic [FRAC_W-1:0] frac;

  fpa_lzc #(.W(EXT_W)) u_lzc (
    .d_i   (mid_i.mag[EXT_W-1:0]),
    .cnt_o (lz)
  );

  always_comb begin
    // left shift stops at exponent 1; anything smaller stays denormal
    room = EW'(mid_i.exp) - EW'(1);
    k    = (EW'(lz) > room) ? room : EW'(lz);
    if (mid_i.mag[SUM_W-1]) begin
      nrm = {mid_i.mag[SUM_W-1:2], |mid_i.mag[1:0]};
      e_n = EW'(mid_i.exp) + EW'(1);
    end else begin
      nrm = mid_i.mag[EXT_W-1:0] << k;
      e_n = EW'(mid_i.exp) - k;
    end
    keep = nrm[EXT_W-1:GRS_W];
    inc  = nrm[GRS_W-1] & ((|nrm[GRS_W-2:0]) | keep[0]);
    rnd  = {1'b0, keep} + RW'(inc);
    if (rnd[SIG_W]) begin
      e_r  = e_n + EW'(1);
      frac = rnd[FRAC_W:1];
    end else begin
      e_r  = rnd[FRAC_W] ? e_n : '0;
      frac = rnd[FRAC_W-1:0];
    end

    ovf_o = 1'b0;
    inv_o = 1'b0;
    if (mid_i.special) begin
      word_o = mid_i.sp_word;
      inv_o  = mid_i.sp_inv;
    end else if (mid_i.mag == '0) begin
      word_o = {mid_i.sign, {(WORD_W-1){1'b0}}};
    end else if (e_r >= EW'(EXP_ONES)) begin
      word_o = {mid_i.sign, EXP_ONES, {FRAC_W{1'b0}}};
      ovf_o  = 1'b1;
    end else begin
      word_o = {mid_i.sign, e_r[EXP_W-1:0], frac};
    end
  end
endmodule

// File: rtl/sp_fadd.sv
module sp_fadd
  import fpa_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic              sub_i,
  input  logic [WORD_W-1:0] a_i,
  input  logic [WORD_W-1:0] b_i,
  output logic              valid_o,
  output logic [WORD_W-1:0] sum_o,
  output logic              ovf_o,
  output logic              inv_o
);
  fpa_mid_t          mid_d, mid_q;
  logic              v1_q;
  logic [WORD_W-1:0] word_d;
  logic              ovf_d, inv_d;

  fpa_align u_align (
    .a_i   (a_i),
    .b_i   (b_i),
    .sub_i (sub_i),
    .mid_o (mid_d)
  );

  fpa_normrnd u_normrnd (
    .mid_i  (mid_q),
    .word_o (word_d),
    .ovf_o  (ovf_d),
    .inv_o  (inv_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      v1_q    <= 1'b0;
      mid_q   <= '0;
      valid_o <= 1'b0;
      sum_o   <= '0;
      ovf_o   <= 1'b0;
      inv_o   <= 1'b0;
    end else begin
      v1_q    <= valid_i;
      mid_q   <= mid_d;
      valid_o <= v1_q;
      sum_o   <= word_d;
      ovf_o   <= v1_q & ovf_d;
      inv_o   <= v1_q & inv_d;
    end
  end
endmodule

// File: rtl/fpa_sva.sv
module fpa_sva
  import fpa_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              valid_i,
  input logic              sub_i,
  input logic [WORD_W-1:0] a_i,
  input logic [WORD_W-1:0] b_i,
  input logic              valid_o,
  input logic [WORD_W-1:0] sum_o,
  input logic              ovf_o,
  input logic              inv_o
);
  logic vd1_q, vd2_q;
  logic a_inf, b_inf, a_nan, b_nan, b_fin;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vd1_q <= 1'b0;
      vd2_q <= 1'b0;
    end else begin
      vd1_q <= valid_i;
      vd2_q <= vd1_q;
    end
  end

  always_comb begin
    a_inf = (a_i[WORD_W-2:FRAC_W] == EXP_ONES) && (a_i[FRAC_W-1:0] == '0);
    b_inf = (b_i[WORD_W-2:FRAC_W] == EXP_ONES) && (b_i[FRAC_W-1:0] == '0);
    a_nan = (a_i[WORD_W-2:FRAC_W] == EXP_ONES) && (a_i[FRAC_W-1:0] != '0);
    b_nan = (b_i[WORD_W-2:FRAC_W] == EXP_ONES) && (b_i[FRAC_W-1:0] != '0);
    b_fin = (b_i[WORD_W-2:FRAC_W] != EXP_ONES);
  end

  a_r1_latency: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o == vd2_q);

  a_r5_ovf_is_inf: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && ovf_o) |-> (sum_o[WORD_W-2:0] == {EXP_ONES, {FRAC_W{1'b0}}}));

  a_r6_nan_in: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && (a_nan || b_nan)) |-> ##2 (valid_o && sum_o == QNAN && !ovf_o));

  a_r7_inf_clash: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && a_inf && b_inf && (a_i[WORD_W-1] != (b_i[WORD_W-1] ^ sub_i)))
    |-> ##2 (valid_o && inv_o && sum_o == QNAN));

  a_r8_inf_pass: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && a_inf && b_fin)
    |-> ##2 (sum_o == $past(a_i, 2) && !ovf_o && !inv_o));

  a_r12_flags_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> (!ovf_o && !inv_o));
endmodule

bind sp_fadd fpa_sva u_sva (.*);

// File: tb/test_sp_fadd.sv
`timescale 1ns/1ps
module test_sp_fadd;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic        sub_i = 1'b0;
  logic [31:0] a_i = '0;
  logic [31:0] b_i = '0;
  logic        valid_o, ovf_o, inv_o;
  logic [31:0] sum_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  bit          q_v[$];
  logic [31:0] q_w[$];
  bit          q_o[$];
  bit          q_i[$];
  string       q_t[$];

  sp_fadd i_sp_fadd (.*);

  always #2.5 clk_i = ~clk_i;

  function automatic real to_real(input logic [31:0] x);
    int  e;
    real m;
    e = int'(x[30:23]);
    if (e == 0) m = real'(int'(x[22:0])) * (2.0 ** (-149.0));
    else        m = real'(int'(x[22:0]) + (1 << 23)) * (2.0 ** real'(e - 150));
    return x[31] ? -m : m;
  endfunction

  task automatic round_dbl(input logic [63:0] d, output logic [31:0] w, output bit ovf);
    longint unsigned s_full, q, rem, half;
    int ue, sh, eo;
    bit den;
    s_full = {11'd0, 1'b1, d[51:0]};
    ue  = int'(d[62:52]) - 1023;
    sh  = 29;
    eo  = ue + 127;
    den = 1'b0;
    ovf = 1'b0;
    if (ue < -126) begin
      sh  = 29 + (-126 - ue);
      den = 1'b1;
      eo  = 0;
    end
    q    = s_full >> sh;
    rem  = s_full & ((64'd1 << sh) - 64'd1);
    half = 64'd1 << (sh - 1);
    if (rem > half || (rem == half && q[0])) q = q + 64'd1;
    if (den) begin
      w = {d[63], 8'(q >> 23), q[22:0]};
    end else begin
      if (q == (64'd1 << 24)) begin
        q  = q >> 1;
        eo = eo + 1;
      end
      if (eo >= 255) begin
        w   = {d[63], 8'hFF, 23'd0};
        ovf = 1'b1;
      end else begin
        w = {d[63], 8'(eo), q[22:0]};
      end
    end
  endtask

  task automatic ref_add(input logic [31:0] a, input logic [31:0] b, input bit sub,
                         output logic [31:0] w, output bit ovf, output bit inv);
    bit  sb, an, bn, ai, bi;
    real r;
    sb  = b[31] ^ sub;
    an  = (a[30:23] == 8'hFF) && (a[22:0] != 0);
    bn  = (b[30:23] == 8'hFF) && (b[22:0] != 0);
    ai  = (a[30:23] == 8'hFF) && (a[22:0] == 0);
    bi  = (b[30:23] == 8'hFF) && (b[22:0] == 0);
    ovf = 1'b0;
    inv = 1'b0;
    if (an || bn || (ai && bi && a[31] != sb)) begin
      w   = 32'h7FC00000;
      inv = (an && !a[22]) || (bn && !b[22]) || (ai && bi);
    end else if (ai) begin
      w = {a[31], 8'hFF, 23'd0};
    end else if (bi) begin
      w = {sb, 8'hFF, 23'd0};
    end else begin
      r = to_real(a) + to_real({sb, b[30:0]});
      if (r == 0.0) w = {a[31] & sb, 31'd0};
      else round_dbl($realtobits(r), w, ovf);
    end
  endtask

  task automatic compare();
    bit ev, eo, ei, ok;
    logic [31:0] ew;
    string et;
    if (q_v.size() == 2) begin
      ev = q_v.pop_front();
      ew = q_w.pop_front();
      eo = q_o.pop_front();
      ei = q_i.pop_front();
      et = q_t.pop_front();
      checks++;
      if (ev) ok = valid_o && sum_o == ew && ovf_o == eo && inv_o == ei;
      else    ok = !valid_o && !ovf_o && !inv_o;
      if (!ok) begin
        fails++;
        $display("FAIL %s: actual v=%0b sum=%08h ovf=%0b inv=%0b expected v=%0b sum=%08h ovf=%0b inv=%0b",
                 et, valid_o, sum_o, ovf_o, inv_o, ev, ew, eo, ei);
      end
    end
  endtask

  task automatic step(input bit v, input logic [31:0] a, input logic [31:0] b,
                      input bit sub, input string tag);
    logic [31:0] w;
    bit o, i;
    @(negedge clk_i);
    compare();
    valid_i = v;
    a_i     = a;
    b_i     = b;
    sub_i   = sub;
    if (v) ref_add(a, b, sub, w, o, i);
    else begin
      w = '0; o = 1'b0; i = 1'b0;
    end
    q_v.push_back(v);
    q_w.push_back(w);
    q_o.push_back(o);
    q_i.push_back(i);
    q_t.push_back(v ? tag : "R1/R12 idle");
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(5.0 * 150000);
    fails++;
    $display("FAIL R1: watchdog expired, actual=running expected=finished");
    finish_run();
  end

  initial begin
    logic [31:0] ra, rb;
    int unsigned r;
    repeat (3) @(negedge clk_i);
    checks++;  // R11 reset state
    if (valid_o || ovf_o || inv_o) begin
      fails++;
      $display("FAIL R11: actual v=%0b ovf=%0b inv=%0b expected 0 0 0", valid_o, ovf_o, inv_o);
    end
    rst_ni = 1'b1;

    step(1, 32'h3F800000, 32'h3F800000, 0, "R2 1+1");
    step(1, 32'h3FC00000, 32'h40100000, 0, "R2 1.5+2.25");
    step(0, 0, 0, 0, "");
    step(1, 32'h40400000, 32'h3F800000, 1, "R3 3-1");
    step(1, 32'hC0400000, 32'hBF800000, 1, "R3 -3-(-1)");
    step(1, 32'h4B800001, 32'h3F800000, 0, "R2 tie to even");
    step(1, 32'h4B800000, 32'h3F800000, 0, "R2 tie stays even");
    step(1, 32'h41200000, 32'h41200000, 1, "R4 x-x");
    step(1, 32'h80000000, 32'h80000000, 0, "R4 -0+-0");
    step(1, 32'h80000000, 32'h00000000, 1, "R4 -0-+0");
    step(1, 32'h00000000, 32'h80000000, 0, "R4 +0+-0");
    step(1, 32'hC1200000, 32'h41200000, 0, "R4 -x+x");
    step(1, 32'h7F7FFFFF, 32'h7F7FFFFF, 0, "R5 max+max");
    step(1, 32'h7F7FFFFF, 32'h73000000, 0, "R5 half ulp tie overflow");
    step(1, 32'h7F7FFFFF, 32'h72800000, 0, "R5 below half no overflow");
    step(1, 32'hFF7FFFFF, 32'h7F7FFFFF, 1, "R5 negative overflow");
    step(1, 32'h7FC00001, 32'h3F800000, 0, "R6 quiet NaN");
    step(1, 32'h3F800000, 32'h7F800001, 0, "R6 signalling NaN");
    step(1, 32'h7F800000, 32'hFF800000, 0, "R7 inf+-inf");
    step(1, 32'h7F800000, 32'h7F800000, 1, "R7 inf-inf");
    step(1, 32'h7F800000, 32'h3F800000, 0, "R8 inf+1");
    step(1, 32'h3F800000, 32'hFF800000, 0, "R8 1+-inf");
    step(1, 32'hFF800000, 32'h7F800000, 1, "R8 -inf-inf");
    step(1, 32'h3F800000, 32'h00000001, 0, "R9 far add");
    step(1, 32'h3F800000, 32'h00000001, 1, "R9 far sub");
    step(1, 32'h4F000000, 32'h33800000, 1, "R9 gap clamp");
    step(1, 32'h3F7FFFFF, 32'h33000000, 0, "R10 carry to 1.0");
    step(1, 32'h007FFFFF, 32'h00000001, 0, "R10 denormal to normal");
    step(1, 32'h00000001, 32'h00000001, 0, "R13 denormal add");
    step(1, 32'h00400000, 32'h00400000, 0, "R13 denormal sum normal");
    step(1, 32'h00800000, 32'h00000001, 1, "R13 normal minus tiny");
    step(1, 32'h00800001, 32'h00800000, 1, "R13 cancel to denormal");
    step(0, 0, 0, 0, "");
    step(0, 0, 0, 0, "");

    for (int n = 0; n < 4000; n++) begin
      r  = $urandom;
      ra = $urandom;
      case (r % 5)
        0: rb = $urandom;
        1: rb = {r[9], ra[30:23] + 8'(r[12:10]) - 8'd3, 23'($urandom)};
        2: rb = {~ra[31], ra[30:0] ^ {26'd0, r[15:10]}};
        3: rb = {r[9], ra[30:23] - 8'(r[15:10] % 34), 23'($urandom)};
        default: rb = {r[9], 8'(r[17:16]), 23'($urandom)};
      endcase
      if (r[31:29] == 3'd0) step(0, 0, 0, 0, "");
      else step(1, ra, rb, r[30], "R2 random");
    end

    step(0, 0, 0, 0, "");
    step(0, 0, 0, 0, "");
    @(negedge clk_i);
    compare();
    finish_run();
  end
endmodule